// File: doc/BRIEF.md
# Synthesizer Serial Programming Register

This block is the programming front end of a frequency synthesizer. A host drives three slow asynchronous pins: a shift clock, a serial data line and a load enable. The block samples all three in the system clock domain through synchronizers. Each rising edge of the shift clock moves one data bit into a 32-bit chain. The chain holds a control flag, a 7-bit swallow count (A), a 10-bit main count (N) and a 14-bit reference count (R). While the enable is high, the chain contents pass to the divider value outputs. A and N always follow the chain. R follows only when the control flag is set.

Each field is sent MSB first. A full load is 32 bits: R first, then N, then A, and the control flag last. When the control flag is 0, a short load of 18 bits (N, A, flag) is enough, because R is not written. The bit that falls off the far end of the chain appears on a serial output, so several parts can share one data line in a daisy chain.

Top module: `synth_prog_reg`

## Requirements
- R1: After reset, the A, N and R outputs and the serial output are all zero.
- R2: Each rising edge of the shift clock shifts exactly one bit into the chain. Holding the shift clock high or low for any time adds no further shifts.
- R3: Chain positions, counted from the data input side, are: index 0 holds the control flag, 1..7 hold A bit 0..6, 8..17 hold N bit 0..9, and 18..31 hold R bit 0..13. A 32-bit load sent MSB first (R bit 13 first, control flag last) places every field at those positions.
- R4: While the enable is high, the A and N outputs take the A and N fields of the chain, whatever the value of the control flag.
- R5: While the enable is high and the control flag (chain index 0) is 1, the R output takes the R field of the chain.
- R6: While the control flag is 0, the R output keeps its previous value, even during an enable pulse.
- R7: While the enable is low, the A, N and R outputs do not change, even while bits are being shifted.
- R8: The serial output always carries chain index 31, which is the bit shifted in 32 shift edges earlier (zero if fewer than 32 shifts have occurred since reset).
- R9: An 18-bit load (N bit 9 first, control flag 0 last) followed by an enable pulse updates A and N and leaves R unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Asynchronous shift clock; the chain shifts on its rising edge |
| sdata_i | input | 1 | Asynchronous serial data, sampled at the shift edge |
| load_en_i | input | 1 | Asynchronous level enable for the output latches |
| sdata_o | output | 1 | Far end of the chain, for daisy chaining |
| a_val_o | output | 7 | Latched swallow count A |
| n_val_o | output | 10 | Latched main count N |
| r_val_o | output | 14 | Latched reference count R |

## Verification
The chain is not visible directly. A corrupt or misaligned chain bit shows up in two places. The serial output shows it on the shift edge that moves it to index 31. Every latched field shows it about three system clocks after the next enable rises. A wrong edge count shows the same way: an extra or missing shift moves every field by one position, so the next load puts a wrong A, N and R on the outputs. A control flag that is stuck or inverted shows when R changes after a short load, or stays put after a full load with the flag set. The bench therefore checks the serial output after every shift and all three outputs after every shift and every pulse.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int unsigned DEF_A_W     = 7;
    localparam int unsigned DEF_N_W     = 10;
    localparam int unsigned DEF_R_W     = 14;
    localparam int unsigned DEF_SYNC    = 2;
    // bit positions in the synchronized pin vector
    localparam int unsigned PIN_DATA    = 0;
    localparam int unsigned PIN_SCLK    = 1;
    localparam int unsigned PIN_LOAD    = 2;
    localparam int unsigned PIN_COUNT   = 3;
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.pipe[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |-> $past(st_q.pipe[0])) else $error("sync delay"); // R2
endmodule

// File: rtl/spr_shift_chain.sv
module spr_shift_chain #(
    parameter int unsigned CHAIN_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_lvl_i,
    input  logic               din_i,
    output logic [CHAIN_W-1:0] chain_o,
    output logic               shift_o
);
    typedef struct packed {
        logic               clk_prev;
        logic [CHAIN_W-1:0] bits;
    } chain_st_t;

    chain_st_t st_d, st_q;
    logic      shift;

    always_comb begin
        st_d          = st_q;
        shift         = sclk_lvl_i & ~st_q.clk_prev;
        st_d.clk_prev = sclk_lvl_i;
        if (shift) begin
            st_d.bits = {st_q.bits[CHAIN_W-2:0], din_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain_o = st_q.bits;
    assign shift_o = shift;

    AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> !shift_o) else $error("double shift"); // R2
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> (chain_o[0] == $past(din_i))) else $error("entry bit"); // R3
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> (chain_o[CHAIN_W-1] == $past(chain_o[CHAIN_W-2]))) else $error("move"); // R8
    AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_o |=> $stable(chain_o)) else $error("idle change"); // R2
endmodule

// File: rtl/spr_latch_bank.sv
module spr_latch_bank #(
    parameter int unsigned A_W = 7,
    parameter int unsigned N_W = 10,
    parameter int unsigned R_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_lvl_i,
    input  logic [A_W+N_W+R_W:0]   chain_i,
    output logic [A_W-1:0]         a_o,
    output logic [N_W-1:0]         n_o,
    output logic [R_W-1:0]         r_o
);
    localparam int unsigned CTL_POS = 0;
    localparam int unsigned A_LO    = 1;
    localparam int unsigned A_HI    = A_LO + A_W - 1;
    localparam int unsigned N_LO    = A_HI + 1;
    localparam int unsigned N_HI    = N_LO + N_W - 1;
    localparam int unsigned R_LO    = N_HI + 1;
    localparam int unsigned R_HI    = R_LO + R_W - 1;

    typedef struct packed {
        logic [A_W-1:0] a_val;
        logic [N_W-1:0] n_val;
        logic [R_W-1:0] r_val;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      ctl;

    always_comb begin
        st_d = st_q;
        ctl  = chain_i[CTL_POS];
        if (load_lvl_i) begin
            st_d.a_val = chain_i[A_HI:A_LO];
            st_d.n_val = chain_i[N_HI:N_LO];
            if (ctl) begin
                st_d.r_val = chain_i[R_HI:R_LO];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_o = st_q.a_val;
    assign n_o = st_q.n_val;
    assign r_o = st_q.r_val;

    AST_AN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_lvl_i |=> (a_o == $past(chain_i[A_HI:A_LO]) && n_o == $past(chain_i[N_HI:N_LO])))
        else $error("A/N follow"); // R4
    AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lvl_i && chain_i[CTL_POS]) |=> (r_o == $past(chain_i[R_HI:R_LO])))
        else $error("R follow"); // R5
    AST_REF_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_i[CTL_POS] |=> $stable(r_o)) else $error("R changed"); // R6
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !load_lvl_i |=> ($stable(a_o) && $stable(n_o) && $stable(r_o)))
        else $error("hold"); // R7
endmodule

// File: rtl/synth_prog_reg.sv
module synth_prog_reg
    import synth_prog_pkg::*;
#(
    parameter int unsigned A_W    = DEF_A_W,
    parameter int unsigned N_W    = DEF_N_W,
    parameter int unsigned R_W    = DEF_R_W,
    parameter int unsigned SYNC_N = DEF_SYNC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_i,
    input  logic           sdata_i,
    input  logic           load_en_i,
    output logic           sdata_o,
    output logic [A_W-1:0] a_val_o,
    output logic [N_W-1:0] n_val_o,
    output logic [R_W-1:0] r_val_o
);
    localparam int unsigned CHAIN_W = 1 + A_W + N_W + R_W;

    logic [PIN_COUNT-1:0] pin_raw;
    logic [PIN_COUNT-1:0] pin_lvl;
    logic [CHAIN_W-1:0]   chain;
    logic                 shift_pulse;

    always_comb begin
        pin_raw           = '0;
        pin_raw[PIN_DATA] = sdata_i;
        pin_raw[PIN_SCLK] = sclk_i;
        pin_raw[PIN_LOAD] = load_en_i;
    end

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin_sync
        spr_sync #(.STAGES(SYNC_N)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_raw[g]),
            .lvl_o   (pin_lvl[g])
        );
    end

    spr_shift_chain #(.CHAIN_W(CHAIN_W)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_lvl_i (pin_lvl[PIN_SCLK]),
        .din_i      (pin_lvl[PIN_DATA]),
        .chain_o    (chain),
        .shift_o    (shift_pulse)
    );

    spr_latch_bank #(.A_W(A_W), .N_W(N_W), .R_W(R_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_lvl_i (pin_lvl[PIN_LOAD]),
        .chain_i    (chain),
        .a_o        (a_val_o),
        .n_o        (n_val_o),
        .r_o        (r_val_o)
    );

    assign sdata_o = chain[CHAIN_W-1];

    AST_SOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(sdata_o)) else $error("sout moved"); // R8
endmodule

// File: tb/tb_synth_prog_reg.sv
module tb_synth_prog_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        load_en_i = 1'b0;
    logic        sdata_o;
    logic [6:0]  a_val_o;
    logic [9:0]  n_val_o;
    logic [13:0] r_val_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] model = '0;
    logic [6:0]  ea = '0;
    logic [9:0]  en = '0;
    logic [13:0] er = '0;

    always #2 clk = ~clk;

    synth_prog_reg dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .load_en_i(load_en_i), .sdata_o(sdata_o),
        .a_val_o(a_val_o), .n_val_o(n_val_o), .r_val_o(r_val_o)
    );

    function automatic logic [31:0] pack_word(logic [13:0] r, logic [9:0] n, logic [6:0] a, logic c);
        return {r, n, a, c};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_outputs(string tag);
        chk(a_val_o == ea, {tag, " A"}, 32'(a_val_o), 32'(ea));
        chk(n_val_o == en, {tag, " N"}, 32'(n_val_o), 32'(en));
        chk(r_val_o == er, {tag, " R"}, 32'(r_val_o), 32'(er));
    endtask

    // one shift; high_len stretches the high phase of the shift clock
    task automatic shift_bit(logic b, int high_len);
        sdata_i = b;
        wait_cyc(4);
        sclk_i = 1'b1;
        wait_cyc(high_len);
        model = {model[30:0], b};
        chk(sdata_o == model[31], "R8 serial out", 32'(sdata_o), 32'(model[31]));
        check_outputs("R7 hold while shifting");
        sclk_i = 1'b0;
        wait_cyc(4);
    endtask

    task automatic pulse_load();
        load_en_i = 1'b1;
        wait_cyc(6);
        ea = model[7:1];
        en = model[17:8];
        if (model[0]) er = model[31:18];
        load_en_i = 1'b0;
        wait_cyc(6);
    endtask

    task automatic send_bits(logic [31:0] w, int nbits, int high_len);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i], high_len);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] w;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        wait_cyc(5);
        // R1 reset state
        chk(sdata_o == 1'b0, "R1 reset sout", 32'(sdata_o), 0);
        check_outputs("R1 reset");
        rst_n = 1'b1;
        wait_cyc(3);
        check_outputs("R1 after release");

        // R3 R5: directed full load with distinct MSB/LSB patterns
        w = pack_word(14'h2001, 10'h201, 7'h41, 1'b1);
        send_bits(w, 32, 4);
        chk(model == w, "R3 model word", model, w);
        pulse_load();
        check_outputs("R3 R5 full load");

        // R4 R6: full load with flag 0, R must keep 2001
        w = pack_word(14'h1555, 10'h3AA, 7'h2A, 1'b0);
        send_bits(w, 32, 4);
        pulse_load();
        check_outputs("R4 R6 flag clear");

        // R9: short load
        w = {14'h0, 10'h0F3, 7'h19, 1'b0};
        send_bits(w, 18, 4);
        pulse_load();
        check_outputs("R9 short load");

        // R2: long high phases, still one shift per edge
        w = pack_word(14'h3FFF, 10'h155, 7'h7F, 1'b1);
        send_bits(w, 32, 40);
        pulse_load();
        check_outputs("R2 long high phase");

        // R1-style corner: all zeros full load with flag set
        send_bits(32'h1, 32, 4);
        pulse_load();
        check_outputs("R5 all-zero fields");

        // random loads
        for (int k = 0; k < 30; k++) begin
            w = $urandom();
            if (($urandom() % 3) == 0) begin
                send_bits(w, 18, 3 + ($urandom() % 5));
            end else begin
                send_bits(w, 32, 3 + ($urandom() % 5));
            end
            if (($urandom() % 4) != 0) begin
                pulse_load();
                check_outputs("R4 R5 R6 random load");
            end else begin
                wait_cyc(8);
                check_outputs("R7 no pulse");
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule